// File: doc/BRIEF.md
# Mode-Dependent Effective Address Generator

This block forms the address of a storage operand. It adds a 64-bit base value, an optional 64-bit index value and an unsigned 12-bit displacement. It then clears the upper bits of the sum according to a two-bit addressing-mode code. The result is held in an output register that uses a valid/ready handshake, one cycle after the request is accepted.

For a modal load-address operation, the block also supplies the value to be written back to the destination register. In 64-bit mode the whole destination is replaced. In the narrower modes only the low half of the destination changes, and the upper half keeps the register's previous contents, which the caller provides. Mode code `2'b10` is illegal: such a request raises a one-cycle error pulse and yields no address.

Bit numbering: architectural bit 0 (the most significant bit) is vector index 63, and architectural bit 63 is vector index 0. "Upper half" means `[63:32]`.

Top module: `ea_gen`

## Requirements
- R1: With `mode=2'b00` (24-bit), an accepted request yields `out_addr[63:24]=0` and `out_addr[23:0]` equal to the low 24 bits of the sum.
- R2: With `mode=2'b01` (31-bit), an accepted request yields `out_addr[63:31]=0` and `out_addr[30:0]` equal to the low 31 bits of the sum.
- R3: With `mode=2'b11` (64-bit), `out_addr` is the full sum, wrapping modulo 2^64.
- R4: When `idx_vld=0`, the value on `idx` has no effect on the result.
- R5: The displacement is unsigned and zero-extended, so a displacement of `12'hFFF` adds 4095.
- R6: An accepted request with `mode=2'b10` makes `out_err` high for exactly the next cycle, with `out_valid` low.
- R7: In 64-bit mode, `out_la` equals `out_addr`.
- R8: In 24-bit or 31-bit mode, `out_la[63:32]` equals the `old_dest[63:32]` that was presented with the request, and `out_la[31:0]` equals `out_addr[31:0]`.
- R9: A request accepted on one clock edge appears with `out_valid=1` right after that edge.
- R10: While `out_valid=1` and `out_ready=0`, `in_ready` is low and the outputs hold their values.
- R11: After reset, `out_valid=0` and `out_err=0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid (base present) |
| in_ready | output | 1 | Request can be accepted |
| base | input | 64 | Base register value |
| idx | input | 64 | Index register value |
| idx_vld | input | 1 | Index participates in the sum |
| disp | input | 12 | Unsigned displacement |
| mode | input | 2 | Addressing mode: 00=24, 01=31, 11=64, 10 illegal |
| old_dest | input | 64 | Current contents of the load-address destination |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_addr | output | 64 | Truncated effective address |
| out_la | output | 64 | Load-address writeback value |
| out_err | output | 1 | One-cycle pulse for an illegal mode |

## Verification
Every cycle, the assertions check the following: the zero upper field in each narrow mode, the error pulse without a valid result, the preserved upper half of the load-address value, and output stability under backpressure. Only the directed scenarios can show that the arithmetic is correct. This covers the carry into the upper bits, wrap-around at 2^64, the effect of omitting the index and zero-extension of the displacement. The scenarios also show that a new request is taken on the same edge that the pending result drains.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW      = 64,
  parameter int DISP_W  = 12,
  parameter int SHORT_W = 24,
  parameter int MID_W   = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] idx,
  input  logic          idx_vld,
  input  logic [DISP_W-1:0] disp,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] old_dest,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [AW-1:0] out_la,
  output logic          out_err
);
  localparam int HALF = AW / 2;
  localparam logic [AW-1:0] MASK_S = {{(AW-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
  localparam logic [AW-1:0] MASK_M = {{(AW-MID_W){1'b0}}, {MID_W{1'b1}}};

  logic [AW-1:0] sum, addr, la;
  logic          legal, take;

  assign legal = (mode != 2'b10);
  assign take  = in_valid && in_ready;
  assign in_ready = !out_valid || out_ready;
  assign sum = base + (idx_vld ? idx : '0) + {{(AW-DISP_W){1'b0}}, disp};

  always_comb begin
    case (mode)
      2'b00:   addr = sum & MASK_S;
      2'b01:   addr = sum & MASK_M;
      default: addr = sum;
    endcase
  end

  assign la = (mode == 2'b11) ? addr : {old_dest[AW-1:HALF], addr[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_addr  <= '0;
      out_la    <= '0;
    end else begin
      out_err <= take && !legal;
      if (take) begin
        out_valid <= legal;
        if (legal) begin
          out_addr <= addr;
          out_la   <= la;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module ea_gen_chk #(
  parameter int AW      = 64,
  parameter int SHORT_W = 24,
  parameter int MID_W   = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [1:0]    mode,
  input logic [AW-1:0] old_dest,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [AW-1:0] out_la,
  input logic          out_err
);
  localparam int HALF = AW / 2;

  a_r1_short_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == 2'b00) |=> (out_valid && out_addr[AW-1:SHORT_W] == '0));

  a_r2_mid_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == 2'b01) |=> (out_valid && out_addr[AW-1:MID_W] == '0));

  a_r6_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == 2'b10) |=> (out_err && !out_valid));

  a_r6_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> !out_valid);

  a_r8_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !mode[1]) |=> (out_la[AW-1:HALF] == $past(old_dest[AW-1:HALF])
                                            && out_la[HALF-1:0] == out_addr[HALF-1:0]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_la)));
endmodule

bind ea_gen ea_gen_chk #(.AW(AW), .SHORT_W(SHORT_W), .MID_W(MID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mode(mode), .old_dest(old_dest), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_la(out_la), .out_err(out_err)
);

// File: tb/ea_gen_tb.sv
module ea_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, idx_vld = 1'b0, out_ready = 1'b1;
  logic [63:0] base = '0, idx = '0, old_dest = '0;
  logic [11:0] disp = '0;
  logic [1:0]  mode = 2'b00;
  logic        in_ready, out_valid, out_err;
  logic [63:0] out_addr, out_la;
  int checks = 0, errs = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ea_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base(base), .idx(idx), .idx_vld(idx_vld), .disp(disp), .mode(mode),
    .old_dest(old_dest), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_la(out_la), .out_err(out_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_addr(input logic [63:0] b, input logic [63:0] x,
                                             input logic xv, input logic [11:0] d,
                                             input logic [1:0] m);
    logic [63:0] s;
    s = b + (xv ? x : 64'd0) + {52'd0, d};
    if (m == 2'b00) return {40'd0, s[23:0]};
    if (m == 2'b01) return {33'd0, s[30:0]};
    return s;
  endfunction

  task automatic issue(input logic [63:0] b, input logic [63:0] x, input logic xv,
                       input logic [11:0] d, input logic [1:0] m, input logic [63:0] od);
    @(negedge clk);
    base = b; idx = x; idx_vld = xv; disp = d; mode = m; old_dest = od;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic run_one(input string req, input logic [63:0] b, input logic [63:0] x,
                         input logic xv, input logic [11:0] d, input logic [1:0] m,
                         input logic [63:0] od);
    logic [63:0] ea;
    ea = model_addr(b, x, xv, d, m);
    issue(b, x, xv, d, m, od);
    chk({req, " R9 valid"}, {63'd0, out_valid}, 64'd1);
    chk({req, " addr"}, out_addr, ea);
    if (m == 2'b11) chk({req, " R7 la"}, out_la, ea);
    else            chk({req, " R8 la"}, out_la, {od[63:32], ea[31:0]});
  endtask

  task automatic t_reset;
    chk("R11 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R11 out_err", {63'd0, out_err}, 64'd0);
  endtask

  task automatic t_modes;
    run_one("R1", 64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0100_0000, 1'b1, 12'h020, 2'b00, 64'hDEAD_BEEF_1234_5678);
    run_one("R2", 64'h1234_5678_FFFF_FFFF, 64'h1, 1'b1, 12'h001, 2'b01, 64'hCAFE_F00D_0000_0000);
    run_one("R3", 64'h0000_0001_FFFF_FFFF, 64'h1, 1'b1, 12'h000, 2'b11, 64'h5555_5555_5555_5555);
    run_one("R3 wrap", 64'hFFFF_FFFF_FFFF_FF00, 64'h80, 1'b1, 12'h0FF, 2'b11, 64'h0);
  endtask

  task automatic t_index_ignored;
    issue(64'h1000, 64'hFFFF_0000_AAAA_5555, 1'b0, 12'h010, 2'b11, 64'h0);
    chk("R4 index ignored", out_addr, 64'h1010);
  endtask

  task automatic t_disp;
    issue(64'h0, 64'h0, 1'b0, 12'hFFF, 2'b11, 64'h0);
    chk("R5 disp zero-extended", out_addr, 64'd4095);
  endtask

  task automatic t_illegal;
    issue(64'h1234, 64'h0, 1'b0, 12'h0, 2'b10, 64'h0);
    chk("R6 err", {63'd0, out_err}, 64'd1);
    chk("R6 no valid", {63'd0, out_valid}, 64'd0);
    @(posedge clk); #1;
    chk("R6 err one cycle", {63'd0, out_err}, 64'd0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    base = 64'hA000; idx = 0; idx_vld = 0; disp = 12'h0; mode = 2'b11; old_dest = 0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); #1;
    chk("R9 first held", out_addr, 64'hA000);
    base = 64'hB000;
    chk("R10 in_ready low", {63'd0, in_ready}, 64'd0);
    @(posedge clk); #1;
    chk("R10 addr held", out_addr, 64'hA000);
    chk("R10 valid held", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    chk("R10 next taken on drain", out_addr, 64'hB000);
    @(posedge clk); #1;
    chk("R9 valid drops", {63'd0, out_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    t_modes;
    t_index_ignored;
    t_disp;
    t_illegal;
    t_backpressure;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule